// File: doc/BRIEF.md
# Configurable Serial Shift Port

This block is an 8-bit serial shift engine for a small host processor. The host loads and reads the shift register directly, since there is no holding buffer between the host port and the serial path. The same register shifts left on each shift clock, taking the serial input into bit 0 and presenting bit 7 on the serial output. A shift clock comes from one of four selectable sources: a software strobe, a timer compare-match pulse, the rising edge of the clock pin, or the falling edge of the clock pin.

The serial output passes through an output latch. The latch keeps the output steady during the half of the pin clock period in which the far end samples it, so the block samples on one pin edge and changes its output on the other. A 4-bit counter counts shift-clock events and raises an overflow flag when it wraps. In two-wire operation the block detects bus start and stop conditions. It also reports a collision when it releases the line high but the line reads low.

All pins are sampled on the block clock. Pin edges are found by comparing each pin with its value in the previous cycle.

Top module: `shift_port`

## Requirements
- R1: After reset, the data register, the status word and the serial output are all 0.
- R2: A host data write loads the shift register at the next clock edge. If a shift clock falls in the same cycle, the register holds the written value and no shift takes place. The data output always shows the shift register itself.
- R3: The shift moves every bit one place toward bit 7, and the serial input enters bit 0. With clock select 0 a software strobe shifts. With clock select 1 a timer pulse shifts. A pulse from the source that is not selected does nothing.
- R4: Clock select 2 shifts on a rising clock-pin edge and clock select 3 shifts on a falling edge. This also works with wire mode 0 (off).
- R5: With an external source, the serial output equals bit 7 while the latch is open and holds while it is closed. The latch is open while the pin clock is low (select 2) or high (select 3), so the output changes only on the edge opposite the sampling edge.
- R6: With an internal source (select 0 or 1) the latch stays open, so a host write of a new bit 7 reaches the serial output in the same cycle the register changes.
- R7: The counter (status bits 3:0) adds one for each shift event. With an external source it counts both pin edges. It still counts when a host data write overrides the shift.
- R8: When the counter wraps from 15 to 0, the overflow flag (status bit 6) is set.
- R9: A host status write clears each of bits 7, 6 and 5 that is written as 1, and loads bits 3:0 into the counter. The counter load beats a coincident count, and a flag set event beats a coincident clear.
- R10: With wire mode 2 or 3 (two-wire), the serial input falling while the pin clock stays high sets the start flag (bit 7). The serial input rising while the pin clock stays high sets the stop flag (bit 5).
- R11: With wire mode 0 or 1 and an external source, any clock-pin edge in a cycle with the software strobe low sets the start flag. With an internal source, pin edges leave it clear.
- R12: Status bit 4 reads 1 exactly when the wire mode is two-wire, the serial output is 1 and the serial input is 0. Host writes to this bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWire | input | 2 | Wire mode: 0 off, 1 three-wire, 2/3 two-wire |
| cfgClkSel | input | 2 | Shift clock: 0 strobe, 1 timer, 2 pin rise, 3 pin fall |
| wrData | input | 1 | Host write strobe for the data register |
| wrDataVal | input | 8 | Value for a host data write |
| wrStat | input | 1 | Host write strobe for the status word |
| wrStatVal | input | 8 | Value for a host status write |
| swStrobe | input | 1 | Software shift strobe, one cycle |
| timerTick | input | 1 | Timer compare-match pulse, one cycle |
| pinDi | input | 1 | Serial data input |
| pinSck | input | 1 | Serial clock input |
| dataReg | output | 8 | Shift register contents |
| statReg | output | 8 | Status: start, overflow, stop, collision, counter[3:0] |
| pinDo | output | 1 | Serial data output after the latch |

## Verification
Register-based results are due one clock edge after their stimulus: host writes, strobe and timer shifts, counter steps and flag changes. A pin edge driven before edge k is seen at edge k, because it is compared against the previous-cycle copy. The serial output and the collision bit are combinational from registers, so they settle in the same cycle as the state they follow. The bench therefore drives inputs at the falling clock edge and samples one time unit after the following rising edge. For the latch it checks the output both after the sampling edge, while the latch holds, and after the opposite pin edge, when it opens.

// File: rtl/shift_port_pkg.sv
package shift_port_pkg;

  localparam int SR_W  = 8;
  localparam int CNT_W = 4;
  localparam int ST_W  = CNT_W + 4;

  // status bit positions, derived from the counter width
  localparam int ST_START = CNT_W + 3;
  localparam int ST_OVF   = CNT_W + 2;
  localparam int ST_STOP  = CNT_W + 1;
  localparam int ST_COLL  = CNT_W;

  typedef enum logic [1:0] {
    CLK_SOFT     = 2'd0,
    CLK_TIMER    = 2'd1,
    CLK_EXT_RISE = 2'd2,
    CLK_EXT_FALL = 2'd3
  } clkSel_e;

  typedef enum logic [1:0] {
    WIRE_OFF   = 2'd0,
    WIRE_THREE = 2'd1,
    WIRE_TWO   = 2'd2,
    WIRE_TWO_B = 2'd3
  } wireMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic doShift;
    logic latchOpen;
    logic serIn;
  } ctlStrobe_t;

endpackage

// File: rtl/shift_port_ctrl.sv
module shift_port_ctrl
  import shift_port_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    cfgWire,
  input  logic [1:0]    cfgClkSel,
  input  logic          wrData,
  input  logic          wrStat,
  input  logic [CW+3:0] wrStatVal,
  input  logic          swStrobe,
  input  logic          timerTick,
  input  logic          pinDi,
  input  logic          pinSck,
  output ctlStrobe_t    ctl,
  output logic          startFlag,
  output logic          ovfFlag,
  output logic          stopFlag,
  output logic [CW-1:0] cnt
);

  localparam int FLAG_START = CW + 3;
  localparam int FLAG_OVF   = CW + 2;
  localparam int FLAG_STOP  = CW + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic sckQ, diQ;
  logic sckRise, sckFall, sckEdge, sampleEdge;
  logic extSrc, twoWire;
  logic doShift, cntInc;
  logic startEv, stopEv, ovfEv;
  clkSel_e sel;

  assign sel     = clkSel_e'(cfgClkSel);
  assign extSrc  = cfgClkSel[1];
  assign twoWire = cfgWire[1];

  // previous-cycle pin copies for edge finding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      diQ  <= 1'b0;
    end else begin
      sckQ <= pinSck;
      diQ  <= pinDi;
    end
  end

  assign sckRise = pinSck & ~sckQ;
  assign sckFall = ~pinSck & sckQ;
  assign sckEdge = sckRise | sckFall;

  always_comb begin
    sampleEdge = 1'b0;
    doShift    = 1'b0;
    unique case (sel)
      CLK_SOFT:     doShift = swStrobe;
      CLK_TIMER:    doShift = timerTick;
      CLK_EXT_RISE: begin sampleEdge = sckRise; doShift = sckRise; end
      CLK_EXT_FALL: begin sampleEdge = sckFall; doShift = sckFall; end
      default:      doShift = 1'b0;
    endcase
  end

  // external sources count both pin edges
  assign cntInc = extSrc ? sckEdge : doShift;

  always_comb begin
    ctl.loadData  = wrData;
    ctl.doShift   = doShift;
    ctl.serIn     = pinDi;
    if (!extSrc)
      ctl.latchOpen = 1'b1;
    else if (sel == CLK_EXT_RISE)
      ctl.latchOpen = ~sckQ;
    else
      ctl.latchOpen = sckQ;
  end

  // bus condition events
  always_comb begin
    if (twoWire)
      startEv = sckQ & pinSck & diQ & ~pinDi;
    else
      startEv = extSrc & ~swStrobe & sckEdge;
  end
  assign stopEv = twoWire & sckQ & pinSck & ~diQ & pinDi;
  assign ovfEv  = cntInc & ~wrStat & (cnt == CNT_MAX);

  // counter: host load beats count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (wrStat)
      cnt <= wrStatVal[CW-1:0];
    else if (cntInc)
      cnt <= cnt + 1'b1;
  end

  // flags: set event beats write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      stopFlag  <= 1'b0;
    end else begin
      startFlag <= startEv | (startFlag & ~(wrStat & wrStatVal[FLAG_START]));
      ovfFlag   <= ovfEv   | (ovfFlag   & ~(wrStat & wrStatVal[FLAG_OVF]));
      stopFlag  <= stopEv  | (stopFlag  & ~(wrStat & wrStatVal[FLAG_STOP]));
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntInc && !wrStat) |=> cnt == $past(cnt) + 1'b1); // R7
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrStat |=> cnt == $past(wrStatVal[CW-1:0])); // R9
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntInc && !wrStat && cnt == CNT_MAX) |=> (ovfFlag && cnt == '0)); // R8
  AST_START_2W: assert property (@(posedge clk) disable iff (!rstN)
    (twoWire && sckQ && pinSck && diQ && !pinDi) |=> startFlag); // R10
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!twoWire && extSrc && sckEdge && !swStrobe) |=> startFlag); // R11
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wrStatVal[FLAG_START] && !startEv) |=> !startFlag); // R9

endmodule

// File: rtl/shift_port_dp.sv
module shift_port_dp
  import shift_port_pkg::*;
#(
  parameter int DW = SR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic [DW-1:0] wrDataVal,
  output logic [DW-1:0] shiftReg,
  output logic          pinDo
);

  logic [DW-1:0] shiftNext;
  logic          latchQ;

  // left-shift network, serial input at bit 0
  for (genvar b = 0; b < DW; b++) begin : g_shift
    if (b == 0) begin : g_lsb
      assign shiftNext[b] = ctl.serIn;
    end else begin : g_up
      assign shiftNext[b] = shiftReg[b-1];
    end
  end

  // host write wins over a coincident shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (ctl.loadData)
      shiftReg <= wrDataVal;
    else if (ctl.doShift)
      shiftReg <= shiftNext;
  end

  // output latch: follows MSB while open, holds while closed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      latchQ <= 1'b0;
    else if (ctl.latchOpen)
      latchQ <= shiftReg[DW-1];
  end

  assign pinDo = ctl.latchOpen ? shiftReg[DW-1] : latchQ;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadData |=> shiftReg == $past(wrDataVal)); // R2
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doShift && !ctl.loadData) |=>
      (shiftReg[DW-1:1] == $past(shiftReg[DW-2:0]) && shiftReg[0] == $past(ctl.serIn))); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.latchOpen && $past(!ctl.latchOpen)) |-> $stable(pinDo)); // R5
  AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchOpen |-> pinDo == shiftReg[DW-1]); // R6

endmodule

// File: rtl/shift_port.sv
module shift_port
  import shift_port_pkg::*;
#(
  parameter int DATA_W = SR_W,
  parameter int CNT_WIDTH = CNT_W,
  localparam int STAT_W = CNT_WIDTH + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgWire,
  input  logic [1:0]        cfgClkSel,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrDataVal,
  input  logic              wrStat,
  input  logic [STAT_W-1:0] wrStatVal,
  input  logic              swStrobe,
  input  logic              timerTick,
  input  logic              pinDi,
  input  logic              pinSck,
  output logic [DATA_W-1:0] dataReg,
  output logic [STAT_W-1:0] statReg,
  output logic              pinDo
);

  ctlStrobe_t           ctl;
  logic                 startFlag, ovfFlag, stopFlag, collision;
  logic [CNT_WIDTH-1:0] cnt;

  shift_port_ctrl #(.CW(CNT_WIDTH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWire   (cfgWire),
    .cfgClkSel (cfgClkSel),
    .wrData    (wrData),
    .wrStat    (wrStat),
    .wrStatVal (wrStatVal),
    .swStrobe  (swStrobe),
    .timerTick (timerTick),
    .pinDi     (pinDi),
    .pinSck    (pinSck),
    .ctl       (ctl),
    .startFlag (startFlag),
    .ovfFlag   (ovfFlag),
    .stopFlag  (stopFlag),
    .cnt       (cnt)
  );

  shift_port_dp #(.DW(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrDataVal (wrDataVal),
    .shiftReg  (dataReg),
    .pinDo     (pinDo)
  );

  // line released high but read low in two-wire mode
  assign collision = cfgWire[1] & pinDo & ~pinDi;
  assign statReg   = {startFlag, ovfFlag, stopFlag, collision, cnt};

  AST_COLL_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWire[1] |-> !statReg[CNT_WIDTH]); // R12

endmodule

// File: tb/test_shift_port.sv
module test_shift_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgWire = 2'd0, cfgClkSel = 2'd0;
  logic       wrData = 1'b0, wrStat = 1'b0;
  logic [7:0] wrDataVal = 8'h00, wrStatVal = 8'h00;
  logic       swStrobe = 1'b0, timerTick = 1'b0, pinDi = 1'b0, pinSck = 1'b0;
  logic [7:0] dataReg, statReg;
  logic       pinDo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  shift_port i_shift_port (
    .clk(clk), .rstN(rstN), .cfgWire(cfgWire), .cfgClkSel(cfgClkSel),
    .wrData(wrData), .wrDataVal(wrDataVal), .wrStat(wrStat), .wrStatVal(wrStatVal),
    .swStrobe(swStrobe), .timerTick(timerTick), .pinDi(pinDi), .pinSck(pinSck),
    .dataReg(dataReg), .statReg(statReg), .pinDo(pinDo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wrData = 0; wrStat = 0; swStrobe = 0; timerTick = 0;
  endtask

  task automatic hostData(input logic [7:0] v);
    @(negedge clk); wrData = 1; wrDataVal = v; step();
    idle();
  endtask

  task automatic hostStat(input logic [7:0] v);
    @(negedge clk); wrStat = 1; wrStatVal = v; step();
    idle();
  endtask

  task automatic setCfg(input logic [1:0] w, input logic [1:0] s);
    @(negedge clk); cfgWire = w; cfgClkSel = s; step();
  endtask

  task automatic pulseStrobe(input logic di);
    @(negedge clk); pinDi = di; swStrobe = 1; step();
    idle();
  endtask

  task automatic sckTo(input logic v);
    @(negedge clk); pinSck = v; step();
  endtask

  task automatic t_reset();
    check("R1 data", dataReg, 8'h00);
    check("R1 status", statReg, 8'h00);
    check("R1 pinDo", {7'd0, pinDo}, 8'h00);
  endtask

  task automatic t_soft_timer();
    setCfg(2'd1, 2'd0);
    hostStat(8'hE0);
    hostData(8'hA5);
    check("R2 host load", dataReg, 8'hA5);
    pulseStrobe(1'b0);
    check("R3 strobe shift in 0", dataReg, 8'h4A);
    pulseStrobe(1'b1);
    check("R3 strobe shift in 1", dataReg, 8'h95);
    check("R7 count two strobes", statReg, 8'h02);
    // write beats coincident shift
    @(negedge clk); swStrobe = 1; wrData = 1; wrDataVal = 8'h5A; pinDi = 1; step();
    idle();
    check("R2 write wins", dataReg, 8'h5A);
    check("R7 count on overridden shift", statReg, 8'h03);
    // timer pulse ignored under select 0
    @(negedge clk); timerTick = 1; step(); idle();
    check("R3 timer ignored in soft", dataReg, 8'h5A);
    setCfg(2'd1, 2'd1);
    @(negedge clk); timerTick = 1; pinDi = 0; step(); idle();
    check("R3 timer shift", dataReg, 8'hB4);
    pulseStrobe(1'b1);
    check("R3 strobe ignored in timer", dataReg, 8'hB4);
    check("R11 no start with internal src", {7'd0, statReg[7]}, 8'h00);
  endtask

  task automatic t_internal_latch();
    setCfg(2'd1, 2'd0);
    hostData(8'h80);
    check("R6 output follows write high", {7'd0, pinDo}, 8'h01);
    hostData(8'h7F);
    check("R6 output follows write low", {7'd0, pinDo}, 8'h00);
    // internal source: pin edges give no start flag
    hostStat(8'hE0);
    sckTo(1'b1); sckTo(1'b0);
    check("R11 internal pin edges", statReg, 8'h00);
  endtask

  task automatic t_ext_rise();
    setCfg(2'd1, 2'd2);
    hostStat(8'hE0);
    hostData(8'h80);
    check("R5 open while sck low", {7'd0, pinDo}, 8'h01);
    @(negedge clk); pinDi = 0; pinSck = 1; step();
    check("R4 rise shift", dataReg, 8'h00);
    check("R5 held after sampling edge", {7'd0, pinDo}, 8'h01);
    check("R11 edge sets start", statReg, 8'h81);
    hostData(8'h00);
    check("R5 held across host write", {7'd0, pinDo}, 8'h01);
    sckTo(1'b0);
    check("R5 opens on falling edge", {7'd0, pinDo}, 8'h00);
    check("R4 no shift on fall", dataReg, 8'h00);
    check("R7 both edges counted", statReg[3:0], 8'h02);
  endtask

  task automatic t_ext_fall_off();
    setCfg(2'd0, 2'd3);
    hostStat(8'hE0);
    hostData(8'h00);
    @(negedge clk); pinDi = 1; pinSck = 1; step();
    check("R4 no shift on rise in fall mode", dataReg, 8'h00);
    sckTo(1'b0);
    check("R4 fall shift with wire off", dataReg, 8'h01);
    @(negedge clk); pinDi = 0; pinSck = 0; step();
  endtask

  task automatic t_counter_wrap();
    setCfg(2'd1, 2'd0);
    hostStat(8'hEE);
    check("R9 counter load", statReg, 8'h0E);
    pulseStrobe(1'b0);
    check("R8 at max", statReg, 8'h0F);
    pulseStrobe(1'b0);
    check("R8 wrap sets overflow", statReg, 8'h40);
    hostStat(8'h45);
    check("R9 clear overflow and load", statReg, 8'h05);
    // load beats count
    @(negedge clk); swStrobe = 1; wrStat = 1; wrStatVal = 8'h09; step(); idle();
    check("R9 load beats count", statReg, 8'h09);
  endtask

  task automatic t_two_wire();
    setCfg(2'd2, 2'd0);
    @(negedge clk); pinDi = 1; step();
    sckTo(1'b1);
    hostStat(8'hE0);
    @(negedge clk); pinDi = 0; step();
    check("R10 start detect", statReg[7:4], 8'h08);
    // set beats clear
    @(negedge clk); pinDi = 1; step();
    @(negedge clk); pinDi = 0; wrStat = 1; wrStatVal = 8'hE0; step(); idle();
    check("R9 set beats clear", {7'd0, statReg[7]}, 8'h01);
    hostStat(8'hE0);
    @(negedge clk); pinDi = 1; step();
    check("R10 stop detect", statReg[7:4], 8'h02);
    sckTo(1'b0);
    @(negedge clk); pinDi = 0; step();
    hostStat(8'hE0);
    check("R10 data change with sck low", statReg[7:4], 8'h00);
  endtask

  task automatic t_collision();
    setCfg(2'd2, 2'd0);
    hostData(8'h80);
    @(negedge clk); pinDi = 0; step();
    check("R12 collision set", {7'd0, statReg[4]}, 8'h01);
    @(negedge clk); pinDi = 1; step();
    check("R12 collision clear", {7'd0, statReg[4]}, 8'h00);
    @(negedge clk); pinDi = 0; step();
    hostStat(8'hE0);
    check("R12 write cannot clear", {7'd0, statReg[4]}, 8'h01);
    setCfg(2'd1, 2'd0);
    check("R12 none in three-wire", {7'd0, statReg[4]}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    step();
    t_reset();
    t_soft_timer();
    t_internal_latch();
    t_ext_rise();
    t_ext_fall_off();
    t_counter_wrap();
    t_two_wire();
    t_collision();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule